// File: doc/BRIEF.md
# Codec Link Command and Status Slot Controller

This block drives a serial, time-division audio codec link and gives a host a simple way to read and write codec registers over it. The link runs one bit per clock. Each frame has 13 slots of 20 bit times. Slot 0 is a tag that marks which of the other slots hold valid content. Slot 1 carries a command address and slot 2 carries command data. Slots 3 to 12 carry PCM samples. The controller drives a frame sync and the serial output, and it deserializes the serial input in step with them.

The host presents an 8-bit register address, 16-bit write data and a one-cycle write or read strobe. An accepted strobe is held as a pending command and is sent in the command slots of the next frame that starts. A busy flag blocks further strobes until that frame has been transmitted. On the receive side the controller captures the status address and status data that the codec returns. It updates a read-data register, together with an update flag, only when the returned value differs from the value already held. It also writes every valid receive PCM slot, in slot order, into one shared FIFO that the host drains.

Top module: `ac97l_ctrl`

## Requirements
- R1: While `link_en` is high, frames follow each other without gaps. Each frame lasts 13 × 20 = 260 clock cycles and starts with slot 0. `sync` is high for exactly the 20 cycles of slot 0 and low for the rest of the frame. Every slot word is shifted out on `sdata_out` most significant bit (bit 19) first.
- R2: While `link_en` is low, the slot position is held at the start of a frame and both `sync` and `sdata_out` stay low. Transmit and receive have no separate enables: both run whenever `link_en` is high.
- R3: A write strobe with `cmd_addr[7]` = 0 is accepted when the block is not busy. The next frame that starts sends slot 1 = {0, addr[6:0], 12'h000} (address at bit 12, bit 19 = 0 meaning write), slot 2 = data shifted left by 4, and a tag of 20'hE0000 (bit 19 frame valid, bit 18 slot 1 valid, bit 17 slot 2 valid).
- R4: A write strobe with `cmd_addr[7]` = 1 is rejected. `busy` stays low, and the next frame carries no command (tag and slots 1 and 2 are zero).
- R5: A read strobe is accepted when the block is not busy, and `cmd_addr[7]` is discarded. The next frame sends slot 1 = {1, addr[6:0], 12'h000}, slot 2 = 0 and a tag of 20'hC0000.
- R6: A frame without a command has a zero tag and zero slots 1 and 2. Transmit slots 3 to 12 are always zero.
- R7: `busy` rises in the cycle after a strobe is accepted. It stays high through the last bit of the frame that carries the command and is low in the first cycle of the following frame. Strobes that arrive while `busy` is high are ignored.
- R8: Receive slot s (1 to 12) is valid only when bit 19 of the received tag and tag bit 19−s are both set. When slot 1 is valid, `rd_addr` takes its bits 18:12. When slot 2 is valid, its bits 19:4 are the returned status value. Status in slots that are not valid has no effect.
- R9: `rd_data` (zero after reset) takes a returned status value and `rd_upd` is set only when that value differs from the value already held. An accepted read strobe clears `rd_upd`. A value equal to the held one leaves both unchanged.
- R10: Every valid receive slot from 3 to 12, slot 12 included, pushes its bits 19:4 into one shared FIFO in slot order. No slot can be excluded. `fifo_dout` shows the oldest entry, and `fifo_pop` removes it.
- R11: The FIFO holds `FIFO_DEPTH` entries. `fifo_full` is high at that level and pushes while full are dropped. `fifo_empty` is high when no entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Runs the link when high |
| cmd_addr | input | 8 | Host register address; bit 7 set rejects a write |
| cmd_wdata | input | 16 | Host write data |
| wr_stb | input | 1 | One-cycle write request |
| rd_stb | input | 1 | One-cycle read request |
| busy | output | 1 | A command is pending or in flight |
| rd_data | output | 16 | Last changed status value |
| rd_addr | output | 7 | Last captured status address |
| rd_upd | output | 1 | Status value changed since the last read strobe |
| sync | output | 1 | Frame sync, high during slot 0 |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| fifo_pop | input | 1 | Removes the oldest receive sample |
| fifo_dout | output | 16 | Oldest receive sample |
| fifo_empty | output | 1 | Receive FIFO empty |
| fifo_full | output | 1 | Receive FIFO full |

## Verification
On every cycle the assertions check the following. The slot counter steps and wraps correctly. A pending command and an in-flight command never coexist. A rejected write never makes the block busy. The command being sent stays stable through its frame. The status register changes only together with a raised update flag. The FIFO never exceeds its depth and drops pushes when full.

Some behaviour only the bench scenarios can show. These are the exact bit images of the transmitted tag and command slots for every write address and a set of read addresses, and the masking of address bit 7 on reads. They also include the suppression of the update flag when a register is read back with an unchanged value, and the order of FIFO entries across full, partial and invalid frames.

// File: rtl/ac97l_pkg.sv
// Shared constants and types for the codec link controller.
// Assumes a uniform 20-bit slot. PCM samples sit in the upper 16 bits of a slot.
package ac97l_pkg;
    localparam int NSLOTS          = 13;
    localparam int SLOT_BITS       = 20;
    localparam int SAMPLE_BITS     = 16;
    localparam int REG_ADDR_BITS   = 7;
    localparam int HOST_ADDR_BITS  = REG_ADDR_BITS + 1;
    localparam int ADDR_LSB        = 12;
    localparam int DATA_LSB        = 4;
    localparam int RW_POS          = SLOT_BITS - 1;
    localparam int FRAME_VALID_POS = SLOT_BITS - 1;
    localparam int CMD_ADDR_SLOT   = 1;
    localparam int CMD_DATA_SLOT   = 2;
    localparam int FIRST_PCM_SLOT  = 3;
    localparam int SLOT_IDX_W      = $clog2(NSLOTS);
    localparam int BIT_IDX_W       = $clog2(SLOT_BITS);

    typedef logic [SLOT_BITS-1:0]  slot_word_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;

    // One register command as held between the host and the frame.
    typedef struct packed {
        logic                     rd;
        logic [REG_ADDR_BITS-1:0] addr;
        logic [SAMPLE_BITS-1:0]   data;
    } cmd_t;

    localparam slot_idx_t LAST_SLOT = slot_idx_t'(NSLOTS - 1);
    localparam bit_idx_t  LAST_BIT  = bit_idx_t'(SLOT_BITS - 1);
endpackage

// File: rtl/ac97l_slot_seq.sv
// Slot and bit position counter for the serial frame.
// Assumes one bit per clock. The counters return to the start of a frame
// whenever the link is disabled.
module ac97l_slot_seq
    import ac97l_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      link_en,
    output slot_idx_t slot,
    output bit_idx_t  bitc,
    output logic      wrap,
    output logic      sync
);
    // Advance the bit position, then the slot position at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            slot <= '0;
            bitc <= '0;
        end else if (bitc == LAST_BIT) begin
            bitc <= '0;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
            bitc <= bitc + 1'b1;
        end
    end

    // Frame boundary and frame sync decode.
    always_comb begin
        wrap = link_en && (slot == LAST_SLOT) && (bitc == LAST_BIT);
        sync = link_en && (slot == '0);
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        link_en && bitc == LAST_BIT && slot != LAST_SLOT |=> slot == $past(slot) + 1'b1 && bitc == '0); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> slot == '0 && bitc == '0); // R1
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT && bitc <= LAST_BIT); // R1
endmodule

// File: rtl/ac97l_cmd_ctl.sv
// Host command acceptance and transmit slot generation.
// Holds one pending command and one command in flight. A pending command is
// promoted at the start of a frame, or at once while the link is idle.
module ac97l_cmd_ctl
    import ac97l_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      link_en,
    input  slot_idx_t                 slot,
    input  bit_idx_t                  bitc,
    input  logic                      wrap,
    input  logic [HOST_ADDR_BITS-1:0] cmd_addr,
    input  logic [SAMPLE_BITS-1:0]    cmd_wdata,
    input  logic                      wr_stb,
    input  logic                      rd_stb,
    output logic                      busy,
    output logic                      rd_accept,
    output logic                      sdata_out
);
    logic       pend_v, act_v;
    cmd_t       pend, act;
    logic       wr_ok, wr_accept, load;
    slot_word_t cur_word;

    // Acceptance decode: a write needs an in-range address, and both need an idle block.
    always_comb begin
        busy      = pend_v || act_v;
        wr_ok     = wr_stb && !cmd_addr[HOST_ADDR_BITS-1];
        wr_accept = wr_ok && !busy;
        rd_accept = rd_stb && !wr_ok && !busy;
        load      = wrap || (!link_en && !act_v);
    end

    // Pending and in-flight command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            act_v  <= 1'b0;
            pend   <= '0;
            act    <= '0;
        end else begin
            if (load) begin
                act_v  <= pend_v;
                act    <= pend;
                pend_v <= 1'b0;
            end
            if (wr_accept || rd_accept) begin
                pend_v    <= 1'b1;
                pend.rd   <= rd_accept;
                pend.addr <= cmd_addr[REG_ADDR_BITS-1:0];
                pend.data <= wr_accept ? cmd_wdata : '0;
            end
        end
    end

    // Word for the current slot: tag, command address, command data, or zero.
    always_comb begin
        cur_word = '0;
        if (act_v) begin
            if (slot == slot_idx_t'(0)) begin
                cur_word[FRAME_VALID_POS]               = 1'b1;
                cur_word[FRAME_VALID_POS-CMD_ADDR_SLOT] = 1'b1;
                cur_word[FRAME_VALID_POS-CMD_DATA_SLOT] = !act.rd;
            end else if (slot == slot_idx_t'(CMD_ADDR_SLOT)) begin
                cur_word[RW_POS]                          = act.rd;
                cur_word[ADDR_LSB +: REG_ADDR_BITS]       = act.addr;
            end else if (slot == slot_idx_t'(CMD_DATA_SLOT) && !act.rd) begin
                cur_word[DATA_LSB +: SAMPLE_BITS]         = act.data;
            end
        end
    end

    // Serial output, most significant bit first.
    always_comb sdata_out = link_en && cur_word[LAST_BIT - bitc];

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_v, act_v})); // R7
    AST_REJECT_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && cmd_addr[HOST_ADDR_BITS-1] && !rd_stb && !busy |=> !busy); // R4
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        act_v && link_en && !wrap |=> act_v && act == $past(act)); // R3
endmodule

// File: rtl/ac97l_rx_cap.sv
// Receive deserializer, status capture and PCM slot extraction.
// Assumes the slot counters from the sequencer are aligned with the incoming bits.
// A slot word is complete on the clock edge that samples its last bit.
module ac97l_rx_cap
    import ac97l_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     link_en,
    input  slot_idx_t                slot,
    input  bit_idx_t                 bitc,
    input  logic                     sdata_in,
    input  logic                     clr_upd,
    output logic [REG_ADDR_BITS-1:0] stat_addr,
    output logic [SAMPLE_BITS-1:0]   stat_data,
    output logic                     upd,
    output logic                     push,
    output logic [SAMPLE_BITS-1:0]   push_data
);
    logic [SLOT_BITS-2:0]   rx_sh;
    slot_word_t             word, tag;
    logic                   done, slot_ok;
    bit_idx_t               flag_pos;
    logic [SAMPLE_BITS-1:0] new_val;

    // Shift register collecting the bits of the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sh <= '0;
        else if (link_en) rx_sh <= {rx_sh[SLOT_BITS-3:0], sdata_in};
    end

    // Completed word, validity of the current slot and the values carried in it.
    always_comb begin
        word      = {rx_sh, sdata_in};
        done      = link_en && (bitc == LAST_BIT);
        flag_pos  = bit_idx_t'(FRAME_VALID_POS) - bit_idx_t'(slot);
        slot_ok   = (slot != '0) && tag[FRAME_VALID_POS] && tag[flag_pos];
        new_val   = word[DATA_LSB +: SAMPLE_BITS];
        push      = done && slot_ok && (slot >= slot_idx_t'(FIRST_PCM_SLOT));
        push_data = new_val;
    end

    // Tag, status address, status value and change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag       <= '0;
            stat_addr <= '0;
            stat_data <= '0;
            upd       <= 1'b0;
        end else begin
            if (clr_upd) upd <= 1'b0;
            if (done && slot == '0) tag <= word;
            if (done && slot_ok && slot == slot_idx_t'(CMD_ADDR_SLOT))
                stat_addr <= word[ADDR_LSB +: REG_ADDR_BITS];
            if (done && slot_ok && slot == slot_idx_t'(CMD_DATA_SLOT) && new_val != stat_data) begin
                stat_data <= new_val;
                upd       <= 1'b1;
            end
        end
    end

    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd) |-> stat_data != $past(stat_data)); // R9
    AST_DATA_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_data != $past(stat_data) |-> upd); // R9
endmodule

// File: rtl/ac97l_rx_fifo.sv
// Single shared FIFO for the receive PCM samples.
// Pushes while full are dropped. A pop while empty does nothing.
module ac97l_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Level flags and qualified operations.
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R11
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> count == $past(count)); // R11
endmodule

// File: rtl/ac97l_ctrl.sv
// Top of the codec link controller: sequencer, command path, receive capture
// and the shared receive FIFO. Single clock with one serial bit per cycle and
// a synchronous active-low reset.
module ac97l_ctrl
    import ac97l_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      link_en,
    input  logic [HOST_ADDR_BITS-1:0] cmd_addr,
    input  logic [SAMPLE_BITS-1:0]    cmd_wdata,
    input  logic                      wr_stb,
    input  logic                      rd_stb,
    output logic                      busy,
    output logic [SAMPLE_BITS-1:0]    rd_data,
    output logic [REG_ADDR_BITS-1:0]  rd_addr,
    output logic                      rd_upd,
    output logic                      sync,
    output logic                      sdata_out,
    input  logic                      sdata_in,
    input  logic                      fifo_pop,
    output logic [SAMPLE_BITS-1:0]    fifo_dout,
    output logic                      fifo_empty,
    output logic                      fifo_full
);
    slot_idx_t              slot;
    bit_idx_t               bitc;
    logic                   wrap, rd_accept, push;
    logic [SAMPLE_BITS-1:0] push_data;

    ac97l_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .slot(slot), .bitc(bitc), .wrap(wrap), .sync(sync)
    );

    ac97l_cmd_ctl u_cmd (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .slot(slot), .bitc(bitc), .wrap(wrap),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb),
        .busy(busy), .rd_accept(rd_accept), .sdata_out(sdata_out)
    );

    ac97l_rx_cap u_rx (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .slot(slot), .bitc(bitc), .sdata_in(sdata_in), .clr_upd(rd_accept),
        .stat_addr(rd_addr), .stat_data(rd_data), .upd(rd_upd),
        .push(push), .push_data(push_data)
    );

    ac97l_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SAMPLE_BITS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );

    AST_IDLE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> !sync && !sdata_out); // R2
endmodule

// File: tb/tb_ac97l_ctrl.sv
// Self-checking bench: sweeps write addresses, a set of read addresses,
// status change cases and FIFO fill patterns.
module tb_ac97l_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS    = 13;
    localparam int SB    = 20;
    localparam int FB    = NS * SB;
    localparam int DEPTH = 16;

    logic        clk, rst_n, link_en, wr_stb, rd_stb, sdata_in, fifo_pop;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_wdata;
    logic        busy, rd_upd, sync, sdata_out, fifo_empty, fifo_full;
    logic [15:0] rd_data, fifo_dout;
    logic [6:0]  rd_addr;

    ac97l_ctrl #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .busy(busy),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_upd(rd_upd),
        .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
        .fifo_pop(fifo_pop), .fifo_dout(fifo_dout),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    int          checks = 0;
    int          errors = 0;
    logic [19:0] rxw [NS];
    logic [19:0] txw [NS];
    logic        prev_s = 1'b0, cur_s = 1'b0;
    int          wait_ticks, sync_bad;
    logic        busy_first, busy_last;
    bit          finished = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
        prev_s = cur_s;
        cur_s  = sync;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        wait_ticks = 0;
        do begin
            tick();
            wait_ticks++;
        end while (!(cur_s && !prev_s));
    endtask

    // Drive one receive frame and capture one transmit frame from the next frame start.
    task automatic run_frame();
        wait_rise();
        sync_bad = 0;
        for (int i = 0; i < FB; i++) begin
            if (i > 0) tick();
            sdata_in = rxw[i / SB][SB - 1 - (i % SB)];
            txw[i / SB][SB - 1 - (i % SB)] = sdata_out;
            if (sync !== (i < SB)) sync_bad++;
            if (i == 0) busy_first = busy;
            if (i == FB - 1) busy_last = busy;
        end
        sdata_in = 1'b0;
    endtask

    // Pulse a strobe in the middle of a frame.
    task automatic issue(input logic wr, input logic rd, input logic [7:0] a, input logic [15:0] d);
        wait_rise();
        repeat (100) tick();
        cmd_addr = a; cmd_wdata = d; wr_stb = wr; rd_stb = rd;
        tick();
        wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic clear_rx();
        for (int s = 0; s < NS; s++) rxw[s] = '0;
    endtask

    function automatic logic [19:0] tag_of(input logic [12:0] mask);
        logic [19:0] t = '0;
        if (mask != '0) t[19] = 1'b1;
        for (int s = 1; s < NS; s++) if (mask[s]) t[19 - s] = 1'b1;
        return t;
    endfunction

    function automatic logic [15:0] pcm_val(input int s, input int f);
        return 16'((s * 257 + f * 4099) & 16'hFFFF);
    endfunction

    task automatic pop_check(input logic [15:0] exp);
        tick();
        chk("R10 fifo not empty", {31'b0, fifo_empty}, 32'd0);
        chk("R10 fifo order", {16'b0, fifo_dout}, {16'b0, exp});
        fifo_pop = 1'b1;
        tick();
        fifo_pop = 1'b0;
    endtask

    function automatic logic [31:0] upper_or();
        logic [19:0] o = '0;
        for (int s = 3; s < NS; s++) o |= txw[s];
        return {12'b0, o};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; link_en = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        sdata_in = 1'b0; fifo_pop = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        clear_rx();
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // Reset state and idle link
        chk("R7 busy after reset", {31'b0, busy}, 0);
        chk("R9 rd_upd after reset", {31'b0, rd_upd}, 0);
        chk("R9 rd_data after reset", {16'b0, rd_data}, 0);
        chk("R11 fifo empty after reset", {31'b0, fifo_empty}, 1);
        chk("R2 sync idle", {31'b0, sync}, 0);
        chk("R2 sdata_out idle", {31'b0, sdata_out}, 0);

        link_en = 1'b1; prev_s = 1'b1; cur_s = 1'b1;
        run_frame();
        chk("R1 sync shape", sync_bad, 0);
        chk("R6 idle tag", {12'b0, txw[0]}, 0);
        chk("R6 idle slot1", {12'b0, txw[1]}, 0);
        chk("R6 idle slot2", {12'b0, txw[2]}, 0);
        run_frame();
        chk("R1 back to back frames", wait_ticks, 1);
        chk("R1 sync shape second", sync_bad, 0);

        // Write sweep over every legal address
        for (int a = 0; a < 128; a++) begin
            logic [15:0] d = 16'(((a * 769) ^ 16'hA55A) & 16'hFFFF);
            issue(1'b1, 1'b0, 8'(a), d);
            chk("R7 busy after accept", {31'b0, busy}, 1);
            run_frame();
            chk("R3 write tag", {12'b0, txw[0]}, 32'h000E0000);
            chk("R3 write slot1", {12'b0, txw[1]}, {12'b0, 1'b0, 7'(a), 12'h000});
            chk("R3 write slot2", {12'b0, txw[2]}, {12'b0, d, 4'h0});
            chk("R6 pcm slots zero", upper_or(), 0);
            chk("R7 busy through frame", {31'b0, busy_last}, 1);
            tick();
            chk("R7 busy cleared", {31'b0, busy}, 0);
        end

        // Rejected writes
        for (int k = 0; k < 3; k++) begin
            logic [7:0] ha = (k == 0) ? 8'h80 : (k == 1) ? 8'hFF : 8'hC3;
            issue(1'b1, 1'b0, ha, 16'hFFFF);
            chk("R4 reject not busy", {31'b0, busy}, 0);
            run_frame();
            chk("R4 reject tag", {12'b0, txw[0]}, 0);
            chk("R4 reject slot1", {12'b0, txw[1]}, 0);
            chk("R4 reject slot2", {12'b0, txw[2]}, 0);
        end

        // Read sweep with address bit 7 set
        for (int a = 0; a < 16; a++) begin
            logic [6:0] low = 7'(a * 8 + 3);
            issue(1'b0, 1'b1, {1'b1, low}, 16'hFFFF);
            run_frame();
            chk("R5 read tag", {12'b0, txw[0]}, 32'h000C0000);
            chk("R5 read slot1", {12'b0, txw[1]}, {12'b0, 1'b1, low, 12'h000});
            chk("R5 read slot2", {12'b0, txw[2]}, 0);
            tick();
        end

        // Strobe while busy is ignored
        issue(1'b1, 1'b0, 8'h11, 16'h1111);
        cmd_addr = 8'h22; cmd_wdata = 16'h2222; wr_stb = 1'b1;
        tick();
        wr_stb = 1'b0;
        run_frame();
        chk("R7 first command sent", {12'b0, txw[1]}, {12'b0, 1'b0, 7'h11, 12'h000});
        run_frame();
        chk("R7 blocked command dropped", {12'b0, txw[0]}, 0);

        // Status capture and change detection
        rxw[0] = tag_of(13'h0006);
        rxw[1] = {1'b0, 7'h2A, 12'h000};
        rxw[2] = {16'h1234, 4'h0};
        run_frame();
        chk("R8 status address", {25'b0, rd_addr}, 32'h2A);
        chk("R9 status value", {16'b0, rd_data}, 32'h1234);
        chk("R9 flag on change", {31'b0, rd_upd}, 1);
        issue(1'b0, 1'b1, 8'h2A, 16'h0);
        chk("R9 flag cleared by read", {31'b0, rd_upd}, 0);
        run_frame();
        chk("R9 same value no flag", {31'b0, rd_upd}, 0);
        chk("R9 same value kept", {16'b0, rd_data}, 32'h1234);
        rxw[2] = {16'hBEEF, 4'h0};
        run_frame();
        chk("R9 new value flag", {31'b0, rd_upd}, 1);
        chk("R9 new value", {16'b0, rd_data}, 32'hBEEF);
        issue(1'b0, 1'b1, 8'h2A, 16'h0);
        rxw[0] = 20'h60000;
        rxw[1] = {1'b0, 7'h55, 12'h000};
        rxw[2] = {16'h5555, 4'h0};
        run_frame();
        chk("R8 invalid frame value ignored", {16'b0, rd_data}, 32'hBEEF);
        chk("R8 invalid frame address ignored", {25'b0, rd_addr}, 32'h2A);
        chk("R8 invalid frame no flag", {31'b0, rd_upd}, 0);
        tick();

        // FIFO: all PCM slots, slot 12 included
        clear_rx();
        rxw[0] = tag_of(13'h1FF8);
        for (int s = 3; s < NS; s++) rxw[s] = {pcm_val(s, 1), 4'h0};
        run_frame();
        clear_rx();
        for (int s = 3; s < NS; s++) pop_check(pcm_val(s, 1));
        tick();
        chk("R11 empty after drain", {31'b0, fifo_empty}, 1);

        // FIFO: subset of slots
        rxw[0] = tag_of(13'h1090);
        for (int s = 3; s < NS; s++) rxw[s] = {pcm_val(s, 2), 4'h0};
        run_frame();
        clear_rx();
        pop_check(pcm_val(4, 2));
        pop_check(pcm_val(7, 2));
        pop_check(pcm_val(12, 2));
        tick();
        chk("R10 subset count", {31'b0, fifo_empty}, 1);

        // FIFO: frame-valid bit clear, nothing pushed
        rxw[0] = 20'h7FFFF & tag_of(13'h1FF8);
        for (int s = 3; s < NS; s++) rxw[s] = {pcm_val(s, 3), 4'h0};
        run_frame();
        clear_rx();
        chk("R8 no push without frame valid", {31'b0, fifo_empty}, 1);

        // FIFO overflow: 20 pushes into 16 entries
        rxw[0] = tag_of(13'h1FF8);
        for (int s = 3; s < NS; s++) rxw[s] = {pcm_val(s, 4), 4'h0};
        run_frame();
        for (int s = 3; s < NS; s++) rxw[s] = {pcm_val(s, 5), 4'h0};
        run_frame();
        clear_rx();
        chk("R11 full flag", {31'b0, fifo_full}, 1);
        for (int s = 3; s < NS; s++) pop_check(pcm_val(s, 4));
        for (int s = 3; s < 9; s++) pop_check(pcm_val(s, 5));
        tick();
        chk("R11 extra pushes dropped", {31'b0, fifo_empty}, 1);

        // Link disable mid-frame and restart
        wait_rise();
        repeat (50) tick();
        link_en = 1'b0;
        tick();
        chk("R2 sync low when disabled", {31'b0, sync}, 0);
        chk("R2 sdata low when disabled", {31'b0, sdata_out}, 0);
        repeat (10) tick();
        link_en = 1'b1; prev_s = 1'b1; cur_s = 1'b1;
        run_frame();
        chk("R2 restart frame shape", sync_bad, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule